// File: doc/BRIEF.md
# Compact 16-bit Register-Machine CPU Core

`mini16_core` is a small 16-bit processor for housekeeping work inside a larger chip. It has one shared memory port that carries both instruction fetches and data accesses. It keeps sixteen 16-bit general registers, a carry flag, a zero flag and an interrupt-enable flag, and it runs a compact instruction set: add and subtract, single-bit and byte shifts and rotates, bitwise logic, loads and stores addressed by the sum of two registers, jump-and-link, conditional relative branches, and two instructions that build constants from 8-bit halves.

Every instruction takes two cycles. In the fetch cycle the core reads the word at the program counter. In the execute cycle it does the work and, for a load or a store, makes the data access. The port expects read data to arrive in the same cycle the read is asked for. A single level-sensitive interrupt input is checked at each fetch. When the interrupt is taken, the program counter and the two flags go into hidden shadow registers. Software moves these shadow values to and from ordinary registers with explicit instructions, and one instruction returns from the interrupt.

Top module: `mini16_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the core fetches from address 0: `mem_rd` is 1, `mem_addr` is 0 and `mem_wr` is 0. All registers and flags start at zero.
- R2: An instruction word is split into fields: opcode in [15:12], register A in [11:8], register B in [7:4] and register C in [3:0]. Opcode 0 writes C = A + B and sets carry to the carry-out. Opcode 1 writes C = A − B and sets carry to the borrow. Both opcodes set zero when the result is 0.
- R3: Opcode 2 selects a shift, with the sub-code in [7:4] and A as the source. The sub-codes and their results are: 0 logical right, 1 logical left, 2 right with bit 15 kept and bit 14 cleared, 3 left with bit 15 kept and bits 13:0 moved up, 4 rotate right, 5 rotate left, 6 rotate right with the old carry entering bit 15, 7 rotate left with the old carry entering bit 0. Carry takes the bit shifted out (bit 14 for sub-code 3). Zero follows the result.
- R4: Opcode 2 with sub-code 8 moves the high byte down with zero fill, sub-code 9 moves the low byte up with zero fill, and sub-code 10 swaps the two bytes. These leave carry unchanged and update zero.
- R5: Opcodes 3, 4, 5 and 6 write C = A AND B, A OR B, A XOR B and NOT(A XOR B). They update zero and leave carry unchanged.
- R6: Opcode 8 loads C from address A + B. Opcode 7 stores B to address A + C, and `mem_wr` is high for exactly one cycle.
- R7: Opcode 9 jumps to A + B and writes into C the address of the instruction that follows the jump.
- R8: Opcode 10 branches when carry is 1 and opcode 11 branches when zero is 0. The target is the address of the next instruction plus bits [5:0] sign-extended, so a negative offset branches backward.
- R9: Opcode 12 writes C = {8'h00, imm}. Opcode 13 replaces only C[15:8] with imm and keeps C[7:0]. In both, imm is bits [11:4]. Neither changes a flag.
- R10: At a fetch where the interrupt input is high and interrupts are enabled, the core saves PC and flags to the shadow registers, clears the enable flag and fetches next from `IRQ_VEC`. While interrupts are disabled, the input has no effect.
- R11: Opcode 14 uses the sub-code in [7:4] and register C. The sub-codes are: 0 copies the shadow flags to C (bit 1 carry, bit 0 zero), 1 loads the shadow flags from C[1:0], 2 copies the shadow PC to C, 3 loads the shadow PC from C, 4 enables interrupts, 5 disables them, and 6 returns from the interrupt. Return restores PC and flags from the shadows and enables interrupts.
- R12: Each instruction takes one fetch cycle followed by one execute cycle, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the read |

## Verification
The table pass runs each computing instruction on operand pairs chosen to separate neighbouring behaviours. These include results that wrap to zero next to results that do not, a borrow next to an exact cancellation, and through-carry rotates run with carry both set and clear. The results show whether each shift and rotate takes the correct bit into carry and whether the byte moves and logic operations leave carry untouched. Separate programs then cover the other features. One checks the summed load address, a constant built from two halves, and the link value written by a jump. One runs a countdown loop whose backward branch has to sign-extend its offset. In the interrupt program the service routine changes the shadow flags, so after the return the taken branch proves that the restored flags came from the shadow registers. A final program holds the interrupt input high with interrupts disabled and checks that the core never fetches from the vector.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'h0, OP_SUB = 4'h1, OP_SHF = 4'h2, OP_AND = 4'h3,
      OP_OR  = 4'h4, OP_XOR = 4'h5, OP_XNOR = 4'h6, OP_ST = 4'h7,
      OP_LD  = 4'h8, OP_JS  = 4'h9, OP_BRC = 4'hA, OP_BRNZ = 4'hB,
      OP_SET = 4'hC, OP_SETHI = 4'hD, OP_SYS = 4'hE, OP_NOP = 4'hF
   } op_e;

   typedef enum logic [3:0] {
      SH_SRL = 4'h0, SH_SLL = 4'h1, SH_SRA = 4'h2, SH_SLA = 4'h3,
      SH_ROR = 4'h4, SH_ROL = 4'h5, SH_RCR = 4'h6, SH_RCL = 4'h7,
      SH_HI2LO = 4'h8, SH_LO2HI = 4'h9, SH_SWAP = 4'hA
   } shf_e;

   typedef enum logic [3:0] {
      SY_RDFLG = 4'h0, SY_WRFLG = 4'h1, SY_RDPC = 4'h2, SY_WRPC = 4'h3,
      SY_IEN = 4'h4, SY_IDIS = 4'h5, SY_IRET = 4'h6
   } sys_e;

   typedef enum logic {ST_FETCH = 1'b0, ST_EXEC = 1'b1} state_e;
endpackage

// File: rtl/mini16_alu.sv
module mini16_alu
   import mini16_pkg::*;
#(
   parameter int W = 16
) (
   input  op_e          op,
   input  logic [3:0]   sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cout,
   output logic         upd_c,
   output logic         upd_z
);
   localparam int H = W / 2;
   logic [W:0] sum;

   always_comb begin
      y     = '0;
      cout  = cin;
      upd_c = 1'b0;
      upd_z = 1'b0;
      sum   = '0;
      unique case (op)
         OP_ADD: begin
            sum = {1'b0, a} + {1'b0, b};
            y = sum[W-1:0]; cout = sum[W]; upd_c = 1'b1; upd_z = 1'b1;
         end
         OP_SUB: begin
            sum = {1'b0, a} - {1'b0, b};
            y = sum[W-1:0]; cout = sum[W]; upd_c = 1'b1; upd_z = 1'b1;
         end
         OP_SHF: begin
            upd_z = 1'b1;
            upd_c = (sub[3] == 1'b0);
            case (shf_e'(sub))
               SH_SRL:   begin y = {1'b0, a[W-1:1]};           cout = a[0];   end
               SH_SLL:   begin y = {a[W-2:0], 1'b0};           cout = a[W-1]; end
               SH_SRA:   begin y = {a[W-1], 1'b0, a[W-2:1]};   cout = a[0];   end
               SH_SLA:   begin y = {a[W-1], a[W-3:0], 1'b0};   cout = a[W-2]; end
               SH_ROR:   begin y = {a[0], a[W-1:1]};           cout = a[0];   end
               SH_ROL:   begin y = {a[W-2:0], a[W-1]};         cout = a[W-1]; end
               SH_RCR:   begin y = {cin, a[W-1:1]};            cout = a[0];   end
               SH_RCL:   begin y = {a[W-2:0], cin};            cout = a[W-1]; end
               SH_HI2LO: y = {{H{1'b0}}, a[W-1:H]};
               SH_LO2HI: y = {a[H-1:0], {H{1'b0}}};
               SH_SWAP:  y = {a[H-1:0], a[W-1:H]};
               default:  begin y = a; upd_z = 1'b0; end
            endcase
         end
         OP_AND:  begin y = a & b;    upd_z = 1'b1; end
         OP_OR:   begin y = a | b;    upd_z = 1'b1; end
         OP_XOR:  begin y = a ^ b;    upd_z = 1'b1; end
         OP_XNOR: begin y = ~(a ^ b); upd_z = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile #(
   parameter int NREG = 16,
   parameter int W    = 16,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   input  logic [AW-1:0] ra_c,
   output logic [W-1:0]  rd_a,
   output logic [W-1:0]  rd_b,
   output logic [W-1:0]  rd_c
);
   logic [W-1:0] q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q[g] <= '0;
         else if (we && wa == AW'(g))           q[g] <= wd;
      end
   end

   assign rd_a = q[ra_a];
   assign rd_b = q[ra_b];
   assign rd_c = q[ra_c];
endmodule

// File: rtl/mini16_core.sv
module mini16_core
   import mini16_pkg::*;
#(
   parameter int          W        = 16,
   parameter int          NREG     = 16,
   parameter logic [15:0] RESET_PC = 16'h0000,
   parameter logic [15:0] IRQ_VEC  = 16'h0010
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         irq,
   output logic [15:0]  mem_addr,
   output logic         mem_rd,
   output logic         mem_wr,
   output logic [15:0]  mem_wdata,
   input  logic [15:0]  mem_rdata
);
   localparam int AW  = $clog2(NREG);
   localparam int IMW = 6;

   if (W != 16) begin : g_bad_width
      $error("mini16_core: W must be 16, the instruction width");
   end
   if (NREG != 16) begin : g_bad_nreg
      $error("mini16_core: NREG must be 16, register fields are 4 bits");
   end

   state_e       st;
   logic [15:0]  pc, ir, spc;
   logic         c_q, z_q, ie_q;
   logic [1:0]   sflg;
   logic         in_fetch, take_irq;

   op_e          op;
   logic [3:0]   sub;
   logic [7:0]   imm8;
   logic [15:0]  boff;
   logic [15:0]  va, vb, vc, alu_y;
   logic         alu_c, upd_c, upd_z;
   logic         rf_we;
   logic [15:0]  rf_wd;

   assign op       = op_e'(ir[15:12]);
   assign sub      = ir[7:4];
   assign imm8     = ir[11:4];
   assign boff     = {{(16-IMW){ir[IMW-1]}}, ir[IMW-1:0]};
   assign in_fetch = (st == ST_FETCH);
   assign take_irq = in_fetch && irq && ie_q;

   mini16_regfile #(.NREG(NREG), .W(W)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(ir[AW-1:0]), .wd(rf_wd),
      .ra_a(ir[8 +: AW]), .ra_b(ir[4 +: AW]), .ra_c(ir[0 +: AW]),
      .rd_a(va), .rd_b(vb), .rd_c(vc));

   mini16_alu #(.W(W)) u_alu (
      .op(op), .sub(sub), .a(va), .b(vb), .cin(c_q),
      .y(alu_y), .cout(alu_c), .upd_c(upd_c), .upd_z(upd_z));

   always_comb begin
      mem_addr  = pc;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_wdata = vb;
      if (in_fetch) begin
         mem_rd = !take_irq;
      end else if (op == OP_LD) begin
         mem_addr = va + vb;
         mem_rd   = 1'b1;
      end else if (op == OP_ST) begin
         mem_addr = va + vc;
         mem_wr   = 1'b1;
      end
   end

   always_comb begin
      rf_we = 1'b0;
      rf_wd = alu_y;
      if (!in_fetch) begin
         unique case (op)
            OP_ADD, OP_SUB, OP_SHF, OP_AND, OP_OR, OP_XOR, OP_XNOR: rf_we = 1'b1;
            OP_LD:    begin rf_we = 1'b1; rf_wd = mem_rdata; end
            OP_JS:    begin rf_we = 1'b1; rf_wd = pc; end
            OP_SET:   begin rf_we = 1'b1; rf_wd = {8'h00, imm8}; end
            OP_SETHI: begin rf_we = 1'b1; rf_wd = {imm8, vc[7:0]}; end
            OP_SYS: begin
               if (sys_e'(sub) == SY_RDFLG) begin rf_we = 1'b1; rf_wd = {14'h0, sflg}; end
               if (sys_e'(sub) == SY_RDPC)  begin rf_we = 1'b1; rf_wd = spc; end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_FETCH; pc <= RESET_PC; ir <= '0; spc <= '0;
         c_q <= 1'b0; z_q <= 1'b0; ie_q <= 1'b0; sflg <= '0;
      end else if (in_fetch) begin
         if (take_irq) begin
            spc  <= pc;
            sflg <= {c_q, z_q};
            ie_q <= 1'b0;
            pc   <= IRQ_VEC;
         end else begin
            ir <= mem_rdata;
            pc <= pc + 16'd1;
            st <= ST_EXEC;
         end
      end else begin
         st <= ST_FETCH;
         if (upd_c) c_q <= alu_c;
         if (upd_z) z_q <= (alu_y == '0);
         unique case (op)
            OP_JS:   pc <= va + vb;
            OP_BRC:  if (c_q)  pc <= pc + boff;
            OP_BRNZ: if (!z_q) pc <= pc + boff;
            OP_SYS: begin
               case (sys_e'(sub))
                  SY_WRFLG: sflg <= vc[1:0];
                  SY_WRPC:  spc  <= vc;
                  SY_IEN:   ie_q <= 1'b1;
                  SY_IDIS:  ie_q <= 1'b0;
                  SY_IRET:  begin pc <= spc; {c_q, z_q} <= sflg; ie_q <= 1'b1; end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mini16_chk.sv
module mini16_chk #(
   parameter logic [15:0] IRQ_VEC = 16'h0010
) (
   input logic        clk,
   input logic        rst_n,
   input logic        irq,
   input logic        ie,
   input logic        in_fetch,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic [15:0] mem_addr
);
   assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   assert_irq_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fetch && irq && ie) |=> (in_fetch && mem_addr == IRQ_VEC && !ie));

   assert_masked_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fetch && !ie) |-> mem_rd);

   assert_fetch_to_exec_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fetch && !(irq && ie)) |=> !in_fetch);

   assert_exec_to_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_fetch |=> in_fetch);
endmodule

bind mini16_core mini16_chk #(.IRQ_VEC(IRQ_VEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .ie(ie_q), .in_fetch(in_fetch),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr));

// File: tb/tb_mini16_core.sv
module tb_mini16_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr;
   logic [15:0] mem [0:255];
   int          n_run = 0, n_fail = 0;
   int          cyc = 0;

   always #2 clk = ~clk;

   mini16_core dut (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

   // {instr(A=r1,B=r2 or sub-code,C=r3), a, b, carry in, result, carry, zero}
   localparam logic [66:0] VEC [19] = '{
      {16'h0123, 16'h1234, 16'h0001, 1'b0, 16'h1235, 1'b0, 1'b0},
      {16'h0123, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1},
      {16'h1123, 16'h0005, 16'h0005, 1'b1, 16'h0000, 1'b0, 1'b1},
      {16'h1123, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 1'b1, 1'b0},
      {16'h2103, 16'h8001, 16'h0000, 1'b0, 16'h4000, 1'b1, 1'b0},
      {16'h2113, 16'h8001, 16'h0000, 1'b0, 16'h0002, 1'b1, 1'b0},
      {16'h2123, 16'h8003, 16'h0000, 1'b0, 16'h8001, 1'b1, 1'b0},
      {16'h2133, 16'hC001, 16'h0000, 1'b0, 16'h8002, 1'b1, 1'b0},
      {16'h2143, 16'h0001, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0},
      {16'h2153, 16'h8000, 16'h0000, 1'b0, 16'h0001, 1'b1, 1'b0},
      {16'h2163, 16'h0002, 16'h0000, 1'b1, 16'h8001, 1'b0, 1'b0},
      {16'h2173, 16'h8000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1},
      {16'h2183, 16'hAB12, 16'h0000, 1'b1, 16'h00AB, 1'b1, 1'b0},
      {16'h2193, 16'hAB12, 16'h0000, 1'b0, 16'h1200, 1'b0, 1'b0},
      {16'h21A3, 16'hAB12, 16'h0000, 1'b1, 16'h12AB, 1'b1, 1'b0},
      {16'h3123, 16'hF0F0, 16'h0F0F, 1'b1, 16'h0000, 1'b1, 1'b1},
      {16'h4123, 16'hF000, 16'h000F, 1'b0, 16'hF00F, 1'b0, 1'b0},
      {16'h5123, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b1},
      {16'h6123, 16'h00FF, 16'h0F0F, 1'b0, 16'hF00F, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [15:0] ins);
      if (ins[15:12] <= 4'h1) return "R2";
      if (ins[15:12] == 4'h2) return ins[7] ? "R4" : "R3";
      return "R5";
   endfunction

   task automatic start(input int run);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (run) @(negedge clk);
   endtask

   task automatic clear_mem();
      for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int hits, seen1;
      // ---- vector table: one computing instruction per run ----
      for (int i = 0; i < 19; i++) begin
         logic [15:0] ins, a, b, res; logic ci, co, zo;
         {ins, a, b, ci, res, co, zo} = VEC[i];
         rst_n = 1'b0;
         clear_mem();
         mem[0]  = 16'hC018;
         mem[1]  = ci ? 16'h1089 : 16'h0009;
         mem[2]  = {4'hC, a[7:0], 4'h1};
         mem[3]  = {4'hD, a[15:8], 4'h1};
         mem[4]  = {4'hC, b[7:0], 4'h2};
         mem[5]  = {4'hD, b[15:8], 4'h2};
         mem[6]  = ins;
         mem[7]  = 16'hC014; mem[8]  = 16'hA001; mem[9]  = 16'hC004;
         mem[10] = 16'hC006; mem[11] = 16'hB001; mem[12] = 16'hC016;
         mem[13] = 16'hC807; mem[14] = 16'h7037;
         mem[15] = 16'hC817; mem[16] = 16'h7047;
         mem[17] = 16'hC827; mem[18] = 16'h7067;
         mem[19] = 16'hC14A; mem[20] = 16'h9A0B;
         start(70);
         check({req_of(ins), " result"}, mem[8'h80], res);
         check({req_of(ins), " carry"},  mem[8'h81], {15'h0, co});
         check({req_of(ins), " zero"},   mem[8'h82], {15'h0, zo});
      end

      // ---- directed: reset, timing, load, link, constant, backward branch ----
      rst_n = 1'b0;
      clear_mem();
      mem[0]  = 16'hC401; mem[1]  = 16'hC052; mem[2]  = 16'h8123;
      mem[3]  = 16'hC807; mem[4]  = 16'h7037; mem[5]  = 16'hC345;
      mem[6]  = 16'hD125; mem[7]  = 16'hC817; mem[8]  = 16'h7057;
      mem[9]  = 16'hC10A; mem[10] = 16'h9A0B; mem[11] = 16'hCFF5;
      mem[12] = 16'hF000; mem[13] = 16'hF000; mem[14] = 16'hF000; mem[15] = 16'hF000;
      mem[16] = 16'hC827; mem[17] = 16'h70B7; mem[18] = 16'hC03C;
      mem[19] = 16'hC01D; mem[20] = 16'hC00E; mem[21] = 16'h0EDE;
      mem[22] = 16'h1CDC; mem[23] = 16'hB03D; mem[24] = 16'hC837;
      mem[25] = 16'h70E7; mem[26] = 16'hC1AF; mem[27] = 16'h9F0B;
      mem[8'h45] = 16'hBEEF;
      repeat (2) @(negedge clk);
      check("R1 rd in reset",   {15'h0, mem_rd}, 16'h0001);
      check("R1 addr in reset", mem_addr, 16'h0000);
      check("R1 wr in reset",   {15'h0, mem_wr}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 first fetch addr", mem_addr, 16'h0000);
      @(negedge clk);
      check("R12 exec cycle no read", {15'h0, mem_rd}, 16'h0000);
      @(negedge clk);
      check("R12 second fetch rd",   {15'h0, mem_rd}, 16'h0001);
      check("R12 second fetch addr", mem_addr, 16'h0001);
      repeat (120) @(negedge clk);
      check("R6 load A+B",        mem[8'h80], 16'hBEEF);
      check("R9 two-half const",  mem[8'h81], 16'h1234);
      check("R7 link value",      mem[8'h82], 16'h000B);
      check("R8 backward loop",   mem[8'h83], 16'h0003);
      check("R6 source untouched",mem[8'h45], 16'hBEEF);

      // ---- interrupt entry, shadow moves, return with modified flags ----
      rst_n = 1'b0;
      clear_mem();
      mem[0] = 16'hE040; mem[1] = 16'h0009; mem[2] = 16'hC024; mem[3] = 16'hA001;
      mem[4] = 16'h9405; mem[5] = 16'hC927; mem[6] = 16'h7047; mem[7] = 16'hC08C;
      mem[8] = 16'h9C05;
      mem[16] = 16'hE026; mem[17] = 16'hE00A; mem[18] = 16'hC907; mem[19] = 16'h7067;
      mem[20] = 16'hC917; mem[21] = 16'h70A7; mem[22] = 16'hC02A; mem[23] = 16'hE01A;
      mem[24] = 16'hE060;
      start(12);
      for (int k = 0; k < 200; k++) begin
         if (mem_rd && mem_addr == 16'h0003) break;
         @(negedge clk);
      end
      irq = 1'b1;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (mem_rd && mem_addr == 16'h0010) break;
      end
      check("R10 vector fetch", mem_addr, 16'h0010);
      irq = 1'b0;
      repeat (100) @(negedge clk);
      check("R10 saved PC",            mem[8'h90], 16'h0003);
      check("R11 shadow flags read",   mem[8'h91], 16'h0001);
      check("R11 return uses shadows", mem[8'h92], 16'h0002);

      // ---- interrupt held high while disabled ----
      rst_n = 1'b0;
      clear_mem();
      mem[0] = 16'hC014; mem[1] = 16'h9405;
      start(4);
      irq = 1'b1;
      hits = 0; seen1 = 0;
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         if (mem_rd && mem_addr == 16'h0010) hits++;
         if (mem_rd && mem_addr == 16'h0001) seen1++;
      end
      irq = 1'b0;
      check("R10 masked no vector fetch", 16'(hits), 16'h0000);
      check("R10 masked keeps running",   16'(seen1 > 0), 16'h0001);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule